// File: doc/BRIEF.md
# Direct-Mode DMA Stream Engine

This block is the data path of one DMA stream when it runs without a FIFO. Each request from a peripheral moves exactly one data item between the peripheral data port and a simple memory bus that uses request and grant. A single holding register sits between the two sides. The engine is armed with a direction, an address-increment choice, a base address and an item count. It then serves requests until the count is used up.

When the stream moves data from memory to the peripheral, the engine fetches one item into the holding register ahead of time. A peripheral request can then be answered in the same cycle. When the stream moves data from the peripheral to memory with a fixed memory address, a new request may arrive while the previous item is still waiting for a memory grant. In that case the engine accepts the new item, lets it replace the waiting one, and raises a sticky clash flag. The flag warns that the same destination address is being written twice in a row.

Top module: `dma_direct_stream`

## Requirements
- R1: After reset, `busy`, `tc_flag`, `clash_flag`, `per_ack` and `mem_req` are all 0. While `busy` is 0, neither `per_ack` nor `mem_req` is asserted.
- R2: A one-cycle `cfg_arm` pulse does four things: it loads the item count and base address, latches the direction (`cfg_dir`: 0 = peripheral to memory, 1 = memory to peripheral) and the increment choice, and empties the holding register. `busy` is 1 from the next cycle for as long as items remain.
- R3: Peripheral-to-memory: `per_ack` is high in exactly the cycles in which a request is accepted. Each accepted item is written once (`mem_we`=1) with its data at the current address. Address and data stay stable while the grant is withheld.
- R4: Peripheral-to-memory with increment enabled: while a write waits for its grant, a request is not acknowledged. If the grant arrives in the same cycle, the request is accepted.
- R5: Peripheral-to-memory with increment disabled: a request that arrives while a write waits without grant is acknowledged. Its data replaces the waiting item, `clash_flag` becomes 1, and only the newer data is written.
- R6: `clash_flag` never sets in memory-to-peripheral mode, and never sets with increment enabled.
- R7: `clash_flag` holds until a cycle with `clash_clr`=1. `clash_irq` equals `clash_flag` gated by `clash_ie`.
- R8: Memory-to-peripheral: whenever the holding register is empty and items remain, the engine issues one read (`mem_we`=0). It never fetches more than the remaining count. A request is acknowledged in the same cycle while the register is full, with `per_rdata` carrying the fetched item. While the register is full, no further read is issued.
- R9: With increment enabled, the address grows by ITEM_BYTES (default 4) after each granted memory access. With increment disabled it stays at the base.
- R10: The count falls by one per completed item: a granted write in peripheral-to-memory mode, an acknowledged request in memory-to-peripheral mode. When it reaches zero, `tc_flag` sets and `busy` drops. Later requests get no acknowledge and no memory access until the stream is re-armed.
- R11: Re-arming clears `tc_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_arm | input | 1 | Load configuration and start the stream |
| cfg_dir | input | 1 | 0 = peripheral to memory, 1 = memory to peripheral |
| cfg_addr_inc | input | 1 | Advance the memory address after each access |
| cfg_count | input | CW | Number of items to move |
| cfg_base | input | AW | Starting memory address |
| clash_ie | input | 1 | Interrupt enable for the clash flag |
| clash_clr | input | 1 | Write-one-to-clear for the clash flag |
| per_req | input | 1 | Peripheral transfer request |
| per_ack | output | 1 | Request accepted this cycle |
| per_wdata | input | DW | Item from the peripheral |
| per_rdata | output | DW | Item to the peripheral, valid with `per_ack` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Memory grant; the access completes in this cycle |
| mem_rdata | input | DW | Read data, valid with grant |
| busy | output | 1 | Items remain in the current run |
| tc_flag | output | 1 | Run complete |
| clash_flag | output | 1 | Sticky same-address double-write warning |
| clash_irq | output | 1 | Interrupt from the clash flag |

## Verification
The checker watches several rules on every cycle. An idle stream stays silent. A stalled access keeps its address and data. With increment on, a stalled write holds back the acknowledge. A read request never coincides with an acknowledge. A fixed address stays put after a grant. The clash flag only rises after an acknowledged request meets a stalled fixed-address write, and it stays up until cleared. Completion and activity never overlap. The bench alone can show that the right data reaches the right addresses in the right order, that only the newer item survives a clash, that prefetch stops at the remaining count, and that requests after completion are ignored; it does this under random grant stalls and request gaps.

// File: rtl/dma_dir_pkg.sv
package dma_dir_pkg;

    typedef enum logic {
        XFER_P2M = 1'b0,
        XFER_M2P = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        xfer_dir_e dir;
        logic      addr_inc;
    } stream_cfg_t;

    // May a new peripheral item enter the holding slot this cycle without clobbering?
    function automatic logic p2m_slot_ok(logic held, logic drained, logic cnt_zero, logic cnt_one);
        if (!held)  return !cnt_zero;
        if (drained) return !cnt_zero && !cnt_one;
        return 1'b0;
    endfunction

endpackage

// File: rtl/dma_item_counter.sv
module dma_item_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          is_zero,
    output logic          is_one
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (dec && !is_zero)
            count <= count - ONE;
    end

    assign is_zero = (count == '0);
    assign is_one  = (count == ONE);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int AW   = 16,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          advance,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] STEP_W = AW'(STEP);

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= base;
        else if (advance)
            addr <= addr + STEP_W;
    end
endmodule

// File: rtl/dma_hold_slot.sv
module dma_hold_slot #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          drain,
    output logic          valid,
    output logic [DW-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            dout  <= '0;
        end else begin
            if (clear)
                valid <= 1'b0;
            else if (load)
                valid <= 1'b1;      // refill wins over a same-cycle drain
            else if (drain)
                valid <= 1'b0;
            if (load && !clear)
                dout <= din;
        end
    end
endmodule

// File: rtl/dma_direct_stream.sv
module dma_direct_stream
    import dma_dir_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 16,
    parameter int CW         = 8,
    parameter int ITEM_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_arm,
    input  logic          cfg_dir,
    input  logic          cfg_addr_inc,
    input  logic [CW-1:0] cfg_count,
    input  logic [AW-1:0] cfg_base,
    input  logic          clash_ie,
    input  logic          clash_clr,
    input  logic          per_req,
    output logic          per_ack,
    input  logic [DW-1:0] per_wdata,
    output logic [DW-1:0] per_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          tc_flag,
    output logic          clash_flag,
    output logic          clash_irq
);
    stream_cfg_t   cfg_q;
    logic          is_p2m, addr_inc_q;
    logic [CW-1:0] count;
    logic          cnt_zero, cnt_one;
    logic          active;
    logic          hold_valid;
    logic [DW-1:0] hold_data;
    logic          mem_req_i, mem_done;
    logic          p2m_fill, p2m_clash, m2p_give, accept;
    logic          hold_load, hold_drain, item_done;
    logic [DW-1:0] hold_din;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '{dir: XFER_P2M, addr_inc: 1'b0};
        else if (cfg_arm)
            cfg_q <= '{dir: xfer_dir_e'(cfg_dir), addr_inc: cfg_addr_inc};
    end

    assign is_p2m     = (cfg_q.dir == XFER_P2M);
    assign addr_inc_q = cfg_q.addr_inc;
    assign active     = !cnt_zero && !cfg_arm;

    // Memory side: writes drain a filled slot, reads refill an empty one
    assign mem_req_i = active && (is_p2m ? hold_valid : !hold_valid);
    assign mem_done  = mem_req_i && mem_gnt;

    // Peripheral side acceptance
    assign p2m_fill  = per_req && active && p2m_slot_ok(hold_valid, mem_done, cnt_zero, cnt_one);
    assign p2m_clash = per_req && active && hold_valid && !mem_done && !addr_inc_q;
    assign m2p_give  = per_req && active && hold_valid;
    assign accept    = is_p2m ? (p2m_fill || p2m_clash) : m2p_give;

    assign hold_load  = is_p2m ? accept   : mem_done;
    assign hold_din   = is_p2m ? per_wdata : mem_rdata;
    assign hold_drain = is_p2m ? mem_done : accept;
    assign item_done  = is_p2m ? mem_done : accept;

    dma_hold_slot #(.DW(DW)) u_slot (
        .clk   (clk),
        .rst   (rst),
        .clear (cfg_arm),
        .load  (hold_load),
        .din   (hold_din),
        .drain (hold_drain),
        .valid (hold_valid),
        .dout  (hold_data)
    );

    dma_item_counter #(.CW(CW)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_arm),
        .load_val (cfg_count),
        .dec      (item_done),
        .count    (count),
        .is_zero  (cnt_zero),
        .is_one   (cnt_one)
    );

    dma_addr_gen #(.AW(AW), .STEP(ITEM_BYTES)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_arm),
        .base    (cfg_base),
        .advance (mem_done && addr_inc_q),
        .addr    (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst)
            tc_flag <= 1'b0;
        else if (cfg_arm)
            tc_flag <= 1'b0;
        else if (item_done && cnt_one)
            tc_flag <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            clash_flag <= 1'b0;
        else if (is_p2m && p2m_clash)
            clash_flag <= 1'b1;
        else if (clash_clr)
            clash_flag <= 1'b0;
    end

    assign per_ack   = accept;
    assign per_rdata = hold_data;
    assign mem_req   = mem_req_i;
    assign mem_we    = mem_req_i && is_p2m;
    assign mem_wdata = hold_data;
    assign busy      = !cnt_zero;
    assign clash_irq = clash_flag && clash_ie;
endmodule

// File: rtl/dma_stream_chk.sv
module dma_stream_chk #(
    parameter int DW = 32,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_arm,
    input logic          clash_clr,
    input logic          per_ack,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          busy,
    input logic          tc_flag,
    input logic          clash_flag,
    input logic          addr_inc_q
);
    a_r1_idle_silent: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!per_ack && !mem_req));

    a_r3_addr_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt && !cfg_arm) |=> (mem_addr == $past(mem_addr)));

    a_r3_wdata_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mem_gnt && addr_inc_q && !cfg_arm) |=> (mem_wdata == $past(mem_wdata)));

    a_r4_no_ack_while_stalled: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mem_gnt && addr_inc_q) |-> !per_ack);

    a_r6_clash_origin: assert property (@(posedge clk) disable iff (rst)
        $rose(clash_flag) |-> $past(per_ack && mem_we && !mem_gnt && !addr_inc_q));

    a_r7_clash_sticky: assert property (@(posedge clk) disable iff (rst)
        (clash_flag && !clash_clr) |=> clash_flag);

    a_r8_read_means_empty: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !per_ack);

    a_r9_fixed_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt && !addr_inc_q && !cfg_arm) |=> (mem_addr == $past(mem_addr)));

    a_r10_done_is_idle: assert property (@(posedge clk) disable iff (rst)
        tc_flag |-> (!busy && !per_ack));
endmodule

bind dma_direct_stream dma_stream_chk #(.DW(DW), .AW(AW)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_arm    (cfg_arm),
    .clash_clr  (clash_clr),
    .per_ack    (per_ack),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_gnt    (mem_gnt),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .busy       (busy),
    .tc_flag    (tc_flag),
    .clash_flag (clash_flag),
    .addr_inc_q (addr_inc_q)
);

// File: tb/test_dma_direct_stream.sv
module test_dma_direct_stream;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_arm = 1'b0, cfg_dir = 1'b0, cfg_addr_inc = 1'b0;
    logic [CW-1:0] cfg_count = '0;
    logic [AW-1:0] cfg_base = '0;
    logic          clash_ie = 1'b0, clash_clr = 1'b0;
    logic          per_req = 1'b0, per_ack;
    logic [DW-1:0] per_wdata = '0, per_rdata;
    logic          mem_req, mem_we, mem_gnt = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          busy, tc_flag, clash_flag, clash_irq;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] rd_pattern(input logic [AW-1:0] a);
        return {a ^ 16'hA5C3, ~a};
    endfunction

    assign mem_rdata = rd_pattern(mem_addr);

    dma_direct_stream i_dma_direct_stream (
        .clk(clk), .rst(rst), .cfg_arm(cfg_arm), .cfg_dir(cfg_dir),
        .cfg_addr_inc(cfg_addr_inc), .cfg_count(cfg_count), .cfg_base(cfg_base),
        .clash_ie(clash_ie), .clash_clr(clash_clr),
        .per_req(per_req), .per_ack(per_ack), .per_wdata(per_wdata), .per_rdata(per_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .busy(busy), .tc_flag(tc_flag), .clash_flag(clash_flag), .clash_irq(clash_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // sampled combinational outputs from the last tick
    logic          s_ack, s_req, s_we;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_wd, s_rd;

    task automatic tick(input logic req, input logic [DW-1:0] wd, input logic gnt);
        per_req = req; per_wdata = wd; mem_gnt = gnt;
        #1;
        s_ack = per_ack; s_req = mem_req; s_we = mem_we;
        s_addr = mem_addr; s_wd = mem_wdata; s_rd = per_rdata;
        @(negedge clk);
        per_req = 1'b0; mem_gnt = 1'b0;
    endtask

    task automatic arm(input logic dir, input logic inc, input int cnt, input logic [AW-1:0] base);
        cfg_dir = dir; cfg_addr_inc = inc; cfg_count = CW'(cnt); cfg_base = base;
        cfg_arm = 1'b1; per_req = 1'b0; mem_gnt = 1'b0;
        @(negedge clk);
        cfg_arm = 1'b0;
    endtask

    logic [DW-1:0] tx_data [32];
    logic [AW-1:0] wr_addr [32];
    logic [DW-1:0] wr_data [32];
    logic [AW-1:0] rd_addr [32];
    logic [DW-1:0] rx_data [32];
    int n_wr, n_rd, n_rx, r4_bad, r6_bad;

    task automatic run_traffic(input bit p2m, input int items, input int gnt_pct);
        int idx = 0;
        int guard = 0;
        n_wr = 0; n_rd = 0; n_rx = 0; r4_bad = 0; r6_bad = 0;
        while (!tc_flag && guard < 3000) begin
            mem_gnt   = (($urandom % 100) < gnt_pct);
            per_req   = (idx < items) && (($urandom % 4) != 0);
            per_wdata = tx_data[idx % 32];
            #1;
            if (mem_we && !mem_gnt && per_ack) r4_bad++;
            if (mem_req && mem_gnt) begin
                if (mem_we) begin
                    if (n_wr < 32) begin wr_addr[n_wr] = mem_addr; wr_data[n_wr] = mem_wdata; end
                    n_wr++;
                end else begin
                    if (n_rd < 32) rd_addr[n_rd] = mem_addr;
                    n_rd++;
                end
            end
            if (per_ack) begin
                if (!p2m && n_rx < 32) rx_data[n_rx] = per_rdata;
                if (!p2m) n_rx++;
                idx++;
            end
            if (clash_flag) r6_bad++;
            @(negedge clk);
            guard++;
        end
        per_req = 1'b0; mem_gnt = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        #1;
        chk("R1 busy", busy, 0);
        chk("R1 tc_flag", tc_flag, 0);
        chk("R1 clash_flag", clash_flag, 0);
        chk("R1 mem_req", mem_req, 0);
        tick(1'b1, 32'h1111, 1'b1);
        chk("R1 idle ack", s_ack, 0);

        // R2/R4: incrementing write path, a stalled write blocks the next request
        arm(1'b0, 1'b1, 2, 16'h0040);
        chk("R2 busy after arm", busy, 1);
        tick(1'b1, 32'hA0A0_0001, 1'b0);
        chk("R3 first ack", s_ack, 1);
        tick(1'b1, 32'hA0A0_0002, 1'b0);
        chk("R4 stalled no ack", s_ack, 0);
        chk("R3 pending write data", s_wd, 32'hA0A0_0001);
        tick(1'b1, 32'hA0A0_0002, 1'b1);
        chk("R4 ack with grant", s_ack, 1);
        chk("R3 write addr0", s_addr, 16'h0040);
        tick(1'b0, 0, 1'b1);
        chk("R9 inc addr", s_addr, 16'h0044);
        chk("R3 write data1", s_wd, 32'hA0A0_0002);
        chk("R6 no clash with inc", clash_flag, 0);
        chk("R10 tc after two", tc_flag, 1);

        // R5/R7: fixed address, request during stalled write
        clash_ie = 1'b1;
        arm(1'b0, 1'b0, 2, 16'h0080);
        chk("R11 tc cleared", tc_flag, 0);
        tick(1'b1, 32'hD1, 1'b0);
        chk("R5 first ack", s_ack, 1);
        tick(1'b1, 32'hD2, 1'b0);
        chk("R5 clash ack", s_ack, 1);
        chk("R5 clash flag", clash_flag, 1);
        #1;
        chk("R7 irq enabled", clash_irq, 1);
        tick(1'b0, 0, 1'b1);
        chk("R5 newer data written", s_wd, 32'hD2);
        chk("R9 fixed addr first", s_addr, 16'h0080);
        chk("R10 busy mid run", busy, 1);
        tick(1'b1, 32'hD3, 1'b1);
        chk("R5 next ack", s_ack, 1);
        tick(1'b0, 0, 1'b1);
        chk("R9 fixed addr second", s_addr, 16'h0080);
        chk("R5 second data", s_wd, 32'hD3);
        chk("R10 tc fixed", tc_flag, 1);
        chk("R10 busy off", busy, 0);
        chk("R7 sticky", clash_flag, 1);
        tick(1'b1, 32'hEE, 1'b1);
        chk("R10 ignored ack", s_ack, 0);
        chk("R10 ignored mem", s_req, 0);
        clash_ie = 1'b0;
        #1;
        chk("R7 irq masked", clash_irq, 0);
        clash_clr = 1'b1;
        @(negedge clk);
        clash_clr = 1'b0;
        chk("R7 cleared", clash_flag, 0);

        // R8: prefetch path
        arm(1'b1, 1'b1, 2, 16'h0100);
        tick(1'b0, 0, 1'b1);
        chk("R8 prefetch req", s_req, 1);
        chk("R8 prefetch is read", s_we, 0);
        chk("R8 prefetch addr", s_addr, 16'h0100);
        for (int k = 0; k < 3; k++) begin
            tick(1'b0, 0, 1'b1);
            chk("R8 no read when full", s_req, 0);
        end
        tick(1'b1, 0, 1'b1);
        chk("R8 immediate ack", s_ack, 1);
        chk("R8 rdata", s_rd, rd_pattern(16'h0100));
        tick(1'b0, 0, 1'b1);
        chk("R9 read addr inc", s_addr, 16'h0104);
        tick(1'b1, 0, 1'b0);
        chk("R8 second ack", s_ack, 1);
        chk("R8 second rdata", s_rd, rd_pattern(16'h0104));
        tick(1'b0, 0, 1'b1);
        chk("R8 no overfetch", s_req, 0);
        chk("R10 tc m2p", tc_flag, 1);
        chk("R6 no clash m2p", clash_flag, 0);

        // Random runs, incrementing address
        for (int run = 0; run < 8; run++) begin
            bit p2m = run[0];
            int items = 1 + ($urandom % 12);
            int pct = 25 + ($urandom % 70);
            logic [AW-1:0] base = AW'(($urandom % 256) * 4);
            for (int k = 0; k < 32; k++) tx_data[k] = $urandom;
            arm(p2m ? 1'b0 : 1'b1, 1'b1, items, base);
            chk("R11 tc cleared on rearm", tc_flag, 0);
            run_traffic(p2m, items, pct);
            chk("R10 run complete", tc_flag, 1);
            chk("R6 no clash random", r6_bad, 0);
            if (p2m) begin
                chk("R4 no ack on stall", r4_bad, 0);
                chk("R3 write count", n_wr, items);
                for (int i = 0; i < items; i++) begin
                    chk("R9 write addr", wr_addr[i], base + AW'(i * 4));
                    chk("R3 write data", wr_data[i], tx_data[i]);
                end
            end else begin
                chk("R8 read count", n_rd, items);
                chk("R8 delivered count", n_rx, items);
                for (int i = 0; i < items; i++) begin
                    chk("R9 read addr", rd_addr[i], base + AW'(i * 4));
                    chk("R8 delivered data", rx_data[i], rd_pattern(base + AW'(i * 4)));
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule